// File: doc/BRIEF.md
# GPIO Port with Pull Control

This block is a small general-purpose I/O port of up to five pins, controlled through a plain register write/read interface. Five per-pin registers are held inside the block: output data, direction, pull enable, keyboard-interrupt pin enable and edge select. From these registers and two external takeover signals, the block drives the pad controls for every pin: output enable, output value, input buffer enable, pullup enable and pulldown enable. The takeover signals are a shared digital function, with its own output enable and value, and an analog function.

Pin ownership follows a fixed priority. The analog function comes first, then the shared digital function, then the GPIO registers. The pull direction follows the edge select. A rising-edge setting (edge select 1) on a pin with its keyboard-interrupt enable set turns the pullup into a pulldown. A read of the data address returns a value chosen by the direction bit. An output pin returns the stored data bit. An input pin returns the pad level, or 0 while the analog function owns the pin. A build parameter selects a pullup-only variant, which has no pulldown.

The register interface has no flow control: a write is taken on every clock where the write strobe is high, and read data is a combinational function of the read address. The interface has no valid/ready handshake and never applies back-pressure.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0. Every pin then has output enable 0, input buffer enable 1, pullup 0 and pulldown 0.
- R2: The pullup of a pin is 1 when its pull enable is 1, its direction is 0 (input), and either its keyboard-interrupt enable is 0 or its edge select is 0. Otherwise the pullup is 0.
- R3: In the full variant, the pulldown is 1 when pull enable is 1, direction is 0, keyboard-interrupt enable is 1 and edge select is 1. The pullup is then 0. Pullup and pulldown are never both 1.
- R4: Direction 1 (output) forces both pullup and pulldown to 0, whatever the pull enable. Pull enable 0 also forces both to 0.
- R5: When neither takeover is active, output enable equals the direction bit and output value equals the data register bit.
- R6: A read of address 0 returns, per bit, the data register when direction is 1. When direction is 0, it returns the pin input, or 0 if that pin's analog enable is 1.
- R7: When the shared digital enable of a pin is 1 and its analog enable is 0, the pin's output enable and output value come from the shared function's inputs. The read source still follows the direction bit.
- R8: When the analog enable of a pin is 1, its output enable, output value and input buffer enable are 0, even if the shared digital enable is also 1.
- R9: A write to the data register is stored while the pin is an input, and that value is driven once direction is set to 1.
- R10: In the pullup-only variant (parameter HAS_PULLDOWN = 0), pulldown is always 0. Pullup is 1 exactly when pull enable is 1 and direction is 0, and the keyboard-interrupt bits have no effect.
- R11: Register addresses are 0 data, 1 direction, 2 pull enable, 3 keyboard-interrupt enable and 4 edge select; other addresses read 0. A write takes effect on the clock edge where it is sampled. Addresses 1 to 4 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NPINS | Register read data (combinational) |
| pin_in | input | NPINS | Pad input levels |
| alt_en | input | NPINS | Shared digital function enable per pin |
| alt_oe | input | NPINS | Shared digital function output enable |
| alt_out | input | NPINS | Shared digital function output value |
| ana_en | input | NPINS | Analog function enable per pin |
| pad_oe | output | NPINS | Pad output buffer enable |
| pad_out | output | NPINS | Pad output value |
| ibuf_en | output | NPINS | Pad input buffer enable |
| pull_up | output | NPINS | Pullup enable |
| pull_dn | output | NPINS | Pulldown enable |

## Verification
A register write lands on the clock edge that samples it. From there, every pad output and the read data are combinational, so every result is due one edge after its write. Changes to the pin, takeover or read-address inputs show up within the same cycle. The bench changes inputs just after a falling edge. It applies writes to its own model at the rising edge, and compares every output at the next falling edge. Each comparison therefore covers both the registered state and the same-cycle inputs.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_PULL = 3'd2,
    REG_KEN  = 3'd3,
    REG_KEDG = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_cfg,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  pen_q,
  output logic [NPINS-1:0]  ken_q,
  output logic [NPINS-1:0]  kedg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pen_q  <= '0;
      ken_q  <= '0;
      kedg_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_DATA: data_q <= wr_data;
        REG_DIR:  dir_q  <= wr_data;
        REG_PULL: pen_q  <= wr_data;
        REG_KEN:  ken_q  <= wr_data;
        REG_KEDG: kedg_q <= wr_data;
        default:  ;
      endcase
    end
  end

  // Readback of the configuration registers; the data address is resolved in the top.
  always_comb begin
    case (rd_addr)
      REG_DIR:  rd_cfg = dir_q;
      REG_PULL: rd_cfg = pen_q;
      REG_KEN:  rd_cfg = ken_q;
      REG_KEDG: rd_cfg = kedg_q;
      default:  rd_cfg = '0;
    endcase
  end

  // R11: a sampled write is visible on the next cycle
  a_r11_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DIR) |=> (dir_q == $past(wr_data)));
  a_r11_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DATA) |=> (data_q == $past(wr_data)));
  // R1: registers held at zero through reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && pen_q == '0 && data_q == '0));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic ana,
  input  logic alt,
  input  logic alt_oe,
  input  logic alt_out,
  input  logic dir,
  input  logic data,
  input  logic pin,
  output logic oe,
  output logic out,
  output logic ibe,
  output logic rbit
);
  // Ownership priority: analog, then shared digital, then GPIO.
  always_comb begin
    if (ana) begin
      oe  = 1'b0;
      out = 1'b0;
    end else if (alt) begin
      oe  = alt_oe;
      out = alt_out;
    end else begin
      oe  = dir;
      out = data;
    end
    ibe  = ~ana;
    rbit = dir ? data : (pin & ibe);
  end
endmodule

// File: rtl/gpio_pull.sv
module gpio_pull #(
  parameter bit HAS_PULLDOWN = 1'b1
) (
  input  logic pen,
  input  logic dir,
  input  logic ken,
  input  logic kedg,
  output logic up,
  output logic dn
);
  logic armed;
  assign armed = pen & ~dir;

  generate
    if (HAS_PULLDOWN) begin : g_full
      logic flip;
      assign flip = ken & kedg;
      assign up   = armed & ~flip;
      assign dn   = armed & flip;
    end else begin : g_up_only
      logic unused_kbi;
      assign unused_kbi = ken ^ kedg;
      assign up = armed;
      assign dn = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS        = 5,
  parameter bit HAS_PULLDOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  alt_en,
  input  logic [NPINS-1:0]  alt_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  ana_en,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  ibuf_en,
  output logic [NPINS-1:0]  pull_up,
  output logic [NPINS-1:0]  pull_dn
);
  logic [NPINS-1:0] data_q, dir_q, pen_q, ken_q, kedg_q;
  logic [NPINS-1:0] rd_cfg, rd_port;

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_cfg(rd_cfg), .data_q(data_q), .dir_q(dir_q),
    .pen_q(pen_q), .ken_q(ken_q), .kedg_q(kedg_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_mux u_mux (
      .ana(ana_en[i]), .alt(alt_en[i]), .alt_oe(alt_oe[i]), .alt_out(alt_out[i]),
      .dir(dir_q[i]), .data(data_q[i]), .pin(pin_in[i]),
      .oe(pad_oe[i]), .out(pad_out[i]), .ibe(ibuf_en[i]), .rbit(rd_port[i])
    );
    gpio_pull #(.HAS_PULLDOWN(HAS_PULLDOWN)) u_pull (
      .pen(pen_q[i]), .dir(dir_q[i]), .ken(ken_q[i]), .kedg(kedg_q[i]),
      .up(pull_up[i]), .dn(pull_dn[i])
    );
  end

  assign rd_data = (rd_addr == REG_DATA) ? rd_port : rd_cfg;

  // R3: pullup and pulldown never together
  a_r3_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0);
  // R4: an output pin carries no pull
  a_r4_output_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up | pull_dn) & dir_q) == '0);
  // R8: analog ownership turns both buffers off
  a_r8_analog_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | ibuf_en | pad_out) & ana_en) == '0);
  // R6: an input pin under analog control reads 0
  a_r6_analog_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == REG_DATA) |-> ((rd_data & ana_en & ~dir_q) == '0));

  if (!HAS_PULLDOWN) begin : g_chk_up_only
    // R10: the pullup-only variant never pulls down
    a_r10_no_pulldown: assert property (@(posedge clk) disable iff (!rst_n)
      pull_dn == '0);
  end
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int NV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] wr_data = '0, pin_in = '0, alt_en = '0, alt_oe = '0, alt_out = '0, ana_en = '0;
  logic [N-1:0] rd_data, pad_oe, pad_out, ibuf_en, pull_up, pull_dn;
  logic [NV-1:0] v_rd, v_oe, v_out, v_ibe, v_up, v_dn;

  int checks = 0;
  int errors = 0;

  // Behavioural model state: index 0..4 = data, dir, pull, kbi enable, edge select
  int mreg[5][N];
  int vreg[5][NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.NPINS(N), .HAS_PULLDOWN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .alt_en(alt_en),
    .alt_oe(alt_oe), .alt_out(alt_out), .ana_en(ana_en), .pad_oe(pad_oe),
    .pad_out(pad_out), .ibuf_en(ibuf_en), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  gpio_port #(.NPINS(NV), .HAS_PULLDOWN(1'b0)) u_var (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[NV-1:0]),
    .rd_addr(rd_addr), .rd_data(v_rd), .pin_in(pin_in[NV-1:0]), .alt_en(alt_en[NV-1:0]),
    .alt_oe(alt_oe[NV-1:0]), .alt_out(alt_out[NV-1:0]), .ana_en(ana_en[NV-1:0]),
    .pad_oe(v_oe), .pad_out(v_out), .ibuf_en(v_ibe), .pull_up(v_up), .pull_dn(v_dn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < N; b++) mreg[r][b] = 0;
      for (int b = 0; b < NV; b++) vreg[r][b] = 0;
    end
  endtask

  task automatic model_write();
    if (wr_en && wr_addr < 5) begin
      for (int b = 0; b < N; b++) mreg[wr_addr][b] = wr_data[b];
      for (int b = 0; b < NV; b++) vreg[wr_addr][b] = wr_data[b];
    end
  endtask

  // Compare every output of both instances against the requirement rules
  task automatic compare_all();
    int e_oe, e_out, e_ibe, e_up, e_dn, e_rd, pe_in;
    e_oe = 0; e_out = 0; e_ibe = 0; e_up = 0; e_dn = 0; e_rd = 0;
    for (int b = 0; b < N; b++) begin
      pe_in = (mreg[2][b] == 1) && (mreg[1][b] == 0);
      if (ana_en[b]) begin end                                       // R8
      else if (alt_en[b]) begin e_oe |= alt_oe[b] << b; e_out |= alt_out[b] << b; end  // R7
      else begin e_oe |= mreg[1][b] << b; e_out |= mreg[0][b] << b; end                // R5
      if (!ana_en[b]) e_ibe |= 1 << b;
      if (pe_in && mreg[3][b] == 1 && mreg[4][b] == 1) e_dn |= 1 << b;                 // R3
      else if (pe_in) e_up |= 1 << b;                                                   // R2
      if (rd_addr == 0) begin                                                           // R6
        if (mreg[1][b] == 1) e_rd |= mreg[0][b] << b;
        else if (!ana_en[b]) e_rd |= pin_in[b] << b;
      end else if (rd_addr < 5) e_rd |= mreg[rd_addr][b] << b;                          // R11
    end
    chk("R5/R7/R8 pad_oe", pad_oe, e_oe);
    chk("R5/R7/R8 pad_out", pad_out, e_out);
    chk("R8 ibuf_en", ibuf_en, e_ibe);
    chk("R2/R4 pull_up", pull_up, e_up);
    chk("R3/R4 pull_dn", pull_dn, e_dn);
    chk("R6/R11 rd_data", rd_data, e_rd);
    e_up = 0; e_rd = 0;
    for (int b = 0; b < NV; b++) begin
      if (vreg[2][b] == 1 && vreg[1][b] == 0) e_up |= 1 << b;                           // R10
      if (rd_addr == 0) begin
        if (vreg[1][b] == 1) e_rd |= vreg[0][b] << b;
        else if (!ana_en[b]) e_rd |= pin_in[b] << b;
      end else if (rd_addr < 5) e_rd |= vreg[rd_addr][b] << b;
    end
    chk("R10 variant pull_up", v_up, e_up);
    chk("R10 variant pull_dn", v_dn, 0);
    chk("R10 variant rd_data", v_rd, e_rd);
  endtask

  task automatic step();
    @(posedge clk);
    model_write();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[N-1:0];
    step();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible on the outputs
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 ibuf_en", ibuf_en, 5'h1f);
    chk("R1 pull_up", pull_up, 0);
    chk("R1 pull_dn", pull_dn, 0);
    compare_all();

    // R9: data stored while input, driven after direction flip
    wr(0, 5'h15);
    chk("R9 pad_oe still input", pad_oe, 0);
    wr(1, 5'h1f);
    chk("R9 pad_out after dir", pad_out, 5'h15);

    // R2/R3/R4: pull truth table corners
    wr(1, 5'h01);
    wr(2, 5'h1f);
    wr(3, 5'h0c);
    wr(4, 5'h0a);
    chk("R3 pull_dn kbi rising", pull_dn, 5'h08);
    chk("R2 pull_up others", pull_up, 5'h16);
    chk("R10 variant ignores kbi", v_up, 2'b10);
    rd_addr = 3'd4; step();
    chk("R11 readback edge", rd_data, 5'h0a);
    rd_addr = 3'd7; step();
    chk("R11 unused address", rd_data, 0);

    // R7/R8: takeover priority with read source kept
    rd_addr = 3'd0; pin_in = 5'h1f;
    alt_en = 5'h1f; alt_oe = 5'h1f; alt_out = 5'h00; ana_en = 5'h03;
    step();
    chk("R8 analog beats digital oe", pad_oe, 5'h1c);
    chk("R6 read source under takeover", rd_data, 5'h1c | (5'h15 & 5'h01));

    // Random stress against the model
    for (int k = 0; k < 400; k++) begin
      wr_en = ($urandom % 3) == 0;
      wr_addr = 3'($urandom % 6);
      wr_data = N'($urandom);
      rd_addr = 3'($urandom % 6);
      pin_in = N'($urandom); alt_en = N'($urandom); alt_oe = N'($urandom);
      alt_out = N'($urandom); ana_en = N'($urandom) & N'($urandom);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule